// File: doc/BRIEF.md
# GPIO Interrupt Sense and Status Unit

This block watches an 8-line general-purpose input port and turns activity on those lines into one interrupt request. Each line is set up on its own through a small register file on a byte-wide memory-mapped bus. A line can be level-sensitive, either active-high or active-low. It can also be edge-sensitive, on a rising edge, a falling edge, or both edges. Every pin goes through a flop synchronizer before any detection is done.

An edge event is held in a per-line sticky flag until software writes a 1 to that line's bit in the clear register. A level source is never held: its status bit tracks the synchronized pin from one cycle to the next. The raw status is always readable. A separate masked view is the raw status gated by the enable register, and the interrupt output is high whenever any masked bit is set.

The bus is a single-cycle strobe interface. A write takes effect at the clock edge on which `bus_sel` and `bus_wr` are both high. Read data is combinational from the registers selected by `bus_addr`, and it is zero when `bus_sel` is low. Register word addresses are: 0 sense select, 1 both-edges, 2 polarity, 3 enable, 4 raw status, 5 masked status, 6 clear.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the sense, both-edges, polarity and enable registers read 0, raw and masked status read 0 with all pins low, and `irq_out` is low.
- R2: The registers at addresses 0 (sense), 1 (both-edges), 2 (polarity) and 3 (enable) read back the last value written to them.
- R3: A line whose sense bit is 1 is level-sensitive. Its raw status bit equals the synchronized pin when its polarity bit is 1, and the inverted pin when its polarity bit is 0. The bit is not latched: it drops once the pin goes inactive, even without a clear.
- R4: A line whose sense bit and both-edges bit are 0 latches a raw status bit on a 0-to-1 transition of the synchronized pin when its polarity bit is 1, and on a 1-to-0 transition when its polarity bit is 0. The opposite transition sets nothing.
- R5: A line whose sense bit is 0 and both-edges bit is 1 latches on either transition, whatever its polarity bit holds.
- R6: The masked status (address 5) equals raw status AND enable, and `irq_out` is 1 exactly when any masked bit is 1.
- R7: Writing the clear register (address 6) clears the latched edge flag of every line whose data bit is 1. Bits written as 0 leave their flags unchanged.
- R8: When a new edge event and a clear of the same line fall on the same clock edge, the flag ends up set.
- R9: Writes to raw status (address 4) and masked status (address 5) change nothing, and a read of the clear register returns 0.
- R10: Rewriting polarity or both-edges configuration does not clear an edge flag that is already latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | LINES (8) | Asynchronous port inputs |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | AW (3) | Register word address |
| bus_wdata | input | LINES (8) | Write data |
| bus_rdata | output | LINES (8) | Read data, zero when not selected |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench sweeps all five sense modes over pin transition patterns where some lines rise, some fall and some hold, and it computes the expected raw, masked and interrupt values with bit arithmetic. A design that swaps rise and fall, or that honours polarity in both-edges mode, produces the wrong bits in those sweeps. The cycle where a clear and a fresh edge coincide is hit on purpose: a design that lets the clear win loses the second event. Further checks confirm that level status falls with the pin, that zero bits in a clear write are ignored, that writes to the status addresses do nothing, and that a reconfiguration keeps latched flags. A design that latched level sources, cleared too much, or reset flags on configuration writes fails these checks.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int LINES       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pin_in,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [LINES-1:0] bus_wdata,
  output logic [LINES-1:0] bus_rdata,
  output logic             irq_out
);

  localparam logic [AW-1:0] A_SENSE = AW'(0);
  localparam logic [AW-1:0] A_BOTH  = AW'(1);
  localparam logic [AW-1:0] A_POL   = AW'(2);
  localparam logic [AW-1:0] A_EN    = AW'(3);
  localparam logic [AW-1:0] A_RAW   = AW'(4);
  localparam logic [AW-1:0] A_MASK  = AW'(5);
  localparam logic [AW-1:0] A_CLR   = AW'(6);

  logic [LINES-1:0] sync_q [SYNC_STAGES];
  logic [LINES-1:0] pin_s, prev_q;
  logic [LINES-1:0] sense_q, both_q, pol_q, en_q;
  logic [LINES-1:0] lat_q, evt, raw, masked, clr_vec;
  logic             wr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) sync_q[k] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= pin_in;
      for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
      prev_q <= pin_s;
    end
  end

  assign pin_s  = sync_q[SYNC_STAGES-1];
  assign wr_hit = bus_sel & bus_wr;
  assign clr_vec = (wr_hit && bus_addr == A_CLR) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      en_q    <= '0;
    end else if (wr_hit) begin
      case (bus_addr)
        A_SENSE: sense_q <= bus_wdata;
        A_BOTH:  both_q  <= bus_wdata;
        A_POL:   pol_q   <= bus_wdata;
        A_EN:    en_q    <= bus_wdata;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic rise, fall;
    assign rise   = pin_s[i] & ~prev_q[i];
    assign fall   = ~pin_s[i] & prev_q[i];
    assign evt[i] = ~sense_q[i] & (both_q[i] ? (rise | fall) : (pol_q[i] ? rise : fall));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lat_q[i] <= 1'b0;
      else if (evt[i])     lat_q[i] <= 1'b1;
      else if (clr_vec[i]) lat_q[i] <= 1'b0;
    end

    assign raw[i] = sense_q[i] ? ~(pin_s[i] ^ pol_q[i]) : lat_q[i];
  end

  assign masked  = raw & en_q;
  assign irq_out = |masked;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (bus_addr)
        A_SENSE: bus_rdata = sense_q;
        A_BOTH:  bus_rdata = both_q;
        A_POL:   bus_rdata = pol_q;
        A_EN:    bus_rdata = en_q;
        A_RAW:   bus_rdata = raw;
        A_MASK:  bus_rdata = masked;
        default: bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int LINES = 8,
  parameter int AW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic [AW-1:0]    bus_addr,
  input logic [LINES-1:0] bus_rdata,
  input logic             irq_out,
  input logic [LINES-1:0] lat,
  input logic [LINES-1:0] evt,
  input logic [LINES-1:0] clr
);

  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr == AW'(6)) |-> (bus_rdata == '0)); // R9

  AST_IRQ_VS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr == AW'(5)) |-> (irq_out == (|bus_rdata))); // R6

  for (genvar i = 0; i < LINES; i++) begin : g_bit
    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> lat[i]); // R4
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (lat[i] && !clr[i]) |=> lat[i]); // R7
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !evt[i]) |=> !lat[i]); // R7
    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && evt[i]) |=> lat[i]); // R8
  end

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.LINES(LINES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq_out(irq_out), .lat(lat_q), .evt(evt), .clr(clr_vec)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_in = '0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_out;
  int total = 0, bad = 0;
  bit done = 1'b0;

  gpio_irq_ctrl u_dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic pins(input logic [7:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d, exp, en;
    logic [7:0] p0s [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk($sformatf("R1 reset addr %0d", a), d, 8'h00);
    end
    chk("R1 irq after reset", {7'd0, irq_out}, 8'h00);
    rd(3'd6, d); chk("R9 clear reads zero", d, 8'h00);
    // R2 readback
    wr(3'd0, 8'h5A); wr(3'd1, 8'hC3); wr(3'd2, 8'h96); wr(3'd3, 8'h3C);
    rd(3'd0, d); chk("R2 sense", d, 8'h5A);
    rd(3'd1, d); chk("R2 both", d, 8'hC3);
    rd(3'd2, d); chk("R2 pol", d, 8'h96);
    rd(3'd3, d); chk("R2 enable", d, 8'h3C);
    // Mode sweep: 0 level-high, 1 level-low, 2 rise, 3 fall, 4 both
    for (int m = 0; m < 5; m++) begin
      wr(3'd0, (m < 2) ? 8'hFF : 8'h00);
      wr(3'd1, (m == 4) ? 8'hFF : 8'h00);
      wr(3'd2, (m == 0 || m == 2) ? 8'hFF : ((m == 4) ? 8'h55 : 8'h00));
      for (int pi = 0; pi < 4; pi++) begin
        for (int q = 0; q < 2; q++) begin
          logic [7:0] p0, p1;
          p0 = p0s[pi];
          p1 = (q == 0) ? ~p0 : (p0 ^ 8'h0F);
          en = 8'h0F ^ p0 ^ 8'(m * 37);
          wr(3'd3, en);
          pins(p0);
          wr(3'd6, 8'hFF);
          if (m < 2) begin
            rd(3'd4, d);
            chk($sformatf("R3 level before m%0d", m), d, (m == 0) ? p0 : ~p0);
          end
          pins(p1);
          case (m)
            0: exp = p1;
            1: exp = ~p1;
            2: exp = ~p0 & p1;
            3: exp = p0 & ~p1;
            default: exp = p0 ^ p1;
          endcase
          rd(3'd4, d);
          chk($sformatf("%s raw m%0d p0=%02h p1=%02h", (m < 2) ? "R3" : ((m == 4) ? "R5" : "R4"), m, p0, p1), d, exp);
          rd(3'd5, d);
          chk($sformatf("R6 masked m%0d", m), d, exp & en);
          chk($sformatf("R6 irq m%0d", m), {7'd0, irq_out}, {7'd0, |(exp & en)});
        end
      end
    end
    // R3 level not latched: back to inactive drops status without clear
    wr(3'd0, 8'hFF); wr(3'd2, 8'hFF);
    pins(8'hFF);
    rd(3'd4, d); chk("R3 level active", d, 8'hFF);
    pins(8'h00);
    rd(3'd4, d); chk("R3 level drops", d, 8'h00);
    // R7 clear semantics, rising edge mode
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'hFF); wr(3'd6, 8'hFF);
    pins(8'hFF);
    rd(3'd4, d); chk("R4 rise latched", d, 8'hFF);
    wr(3'd6, 8'h00);
    rd(3'd4, d); chk("R7 zero clear no effect", d, 8'hFF);
    wr(3'd6, 8'h0F);
    rd(3'd4, d); chk("R7 partial clear", d, 8'hF0);
    // R10 reconfigure keeps flags
    wr(3'd2, 8'h00); wr(3'd1, 8'hFF);
    rd(3'd4, d); chk("R10 config change keeps flags", d, 8'hF0);
    // R9 status registers read-only
    wr(3'd3, 8'hFF);
    wr(3'd4, 8'hFF); wr(3'd5, 8'h00);
    rd(3'd4, d); chk("R9 raw write ignored", d, 8'hF0);
    rd(3'd5, d); chk("R9 masked write ignored", d, 8'hF0);
    // R8 edge and clear on same edge (both-edges mode)
    wr(3'd6, 8'hFF);
    pins(8'hFE);
    rd(3'd4, d); chk("R5 both edges fall line0", d, 8'h01);
    @(negedge clk);
    pin_in = 8'hFF;
    @(negedge clk);
    wr(3'd6, 8'h01);
    rd(3'd4, d); chk("R8 edge beats clear", d, 8'h01);
    repeat (3) @(negedge clk);
    wr(3'd6, 8'h01);
    rd(3'd4, d); chk("R7 clear without edge", d, 8'h00);
    chk("R6 irq low when idle", {7'd0, irq_out}, 8'h00);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1..all actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule